// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block decides whether the processor core runs, idles or powers down. Software writes an 8-bit power control register. One bit asks for idle, which stops the CPU clock while the peripherals keep running. Another bit asks for power-down, which also drops the oscillator enable. From then on the block watches for the events that end the low-power state. These are an interrupt request that is enabled, or one that is disabled when the recover option is set. A qualified reset pin also ends it.

A second path, hard power-down, is armed by a register bit. It is entered when the external timer-1 pin falls and left when that pin goes high again. During any power-down the block can ask the port logic to float the pins. When a disabled interrupt ends the state, the block raises a one-cycle indication. This tells the sequencer to resume at the next instruction without servicing the interrupt.

The design assumes one always-running clock `clk`, which is the oscillator rate. A machine cycle is `OSC_PER_MC` clocks, counted from the release of `rst_n`. All inputs are synchronous to `clk`.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pcon_q` is 0x00, `cpu_clk_en` and `osc_en` are 1, and `port_float` and `resume_nosvc` are 0.
- R2: A write (`reg_wr_en`=1) while running stores `reg_wr_data` into `pcon_q` at that clock edge. The fields are: bit 7 baud-double, bit 6 hard-power-down arm, bit 5 recover, bit 4 unused (always reads 0), bits 3 and 2 general flags, bit 1 power-down, bit 0 idle.
- R3: A write with both bit 1 and bit 0 set stores bit 1 = 1 and bit 0 = 0, so power-down wins.
- R4: With bit 0 set, `cpu_clk_en` is 0 and `osc_en` stays 1, starting from the cycle after the write edge.
- R5: With bit 1 set, both `cpu_clk_en` and `osc_en` are 0.
- R6: While `cpu_clk_en` is 0, register writes are ignored and `pcon_q` does not change.
- R7: In idle or power-down, any request whose enable bit is 1 clears bits 1 and 0 at the next edge, and `resume_nosvc` stays 0.
- R8: In idle or power-down with bit 5 set and no enabled request, a disabled request clears bits 1 and 0 at the next edge and pulses `resume_nosvc` for exactly one cycle. The exception is request line `NOWAKE_IDX` (default 5), which never wakes when disabled.
- R9: With bit 5 clear, disabled requests leave idle or power-down unchanged.
- R10: While running with bit 6 set, a 1-to-0 transition of `t1_pin` enters hard power-down at the next edge. In that state `cpu_clk_en` and `osc_en` are 0 and `pcon_q` is unchanged. Interrupts are ignored. The state ends at the edge after `t1_pin` is seen high. With bit 6 clear, the transition has no effect.
- R11: `rst_pin` is sampled on the last clock of each machine cycle. Two consecutive high samples clear `pcon_q` to 0x00 and end every low-power state. A single high sample has no effect.
- R12: `port_float` equals `float_cfg` during power-down or hard power-down, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Power control register write strobe |
| reg_wr_data | input | 8 | Register write data |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Interrupt enable per request line |
| t1_pin | input | 1 | External timer-1 pin level |
| rst_pin | input | 1 | External reset pin level |
| float_cfg | input | 1 | Float ports during power-down |
| pcon_q | output | 8 | Power control register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| port_float | output | 1 | Request to float ports 1 to 3 |
| resume_nosvc | output | 1 | One-cycle pulse: resume without service |

## Verification
The hardest situation to reach is the reset-pin qualification. It depends on where the pin's high window falls against a machine-cycle phase the bench does not see directly. The stimulus first holds `rst_pin` high for exactly one machine cycle, which yields a single sample. It then holds the pin low long enough to clear the count. Finally it holds the pin high for three machine cycles, which guarantees two consecutive samples. A second case is the recover wake with only the excluded request line pending, followed by another disabled line, which separates the exclusion from the wake itself.

// File: rtl/pwr_pkg.sv
// Shared definitions for the power state controller.
// Assumes the software-visible bit layout of the power control register.
package pwr_pkg;
    typedef struct packed {
        logic fast_baud;
        logic hard_pd_arm;
        logic recover;
        logic rsvd;
        logic flag1;
        logic flag0;
        logic pd;
        logic idle;
    } pcon_t;
endpackage

// File: rtl/pwr_mc_rst.sv
// Machine-cycle phase counter and reset-pin qualifier.
// Assumes rst_pin is synchronous to clk. rst_hold is high after RST_MC
// consecutive high samples, taken on the last clock of each machine cycle.
module pwr_mc_rst #(
    parameter int OSC_PER_MC = 12,
    parameter int RST_MC     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    output logic rst_hold
);
    localparam int PH_W = $clog2(OSC_PER_MC);
    localparam int RC_W = $clog2(RST_MC + 1);

    logic [PH_W-1:0] phase_q;
    logic [RC_W-1:0] rcnt_q;
    logic            mc_tick;

    assign mc_tick  = (phase_q == PH_W'(OSC_PER_MC - 1));
    assign rst_hold = (rcnt_q == RC_W'(RST_MC));

    // Advance the machine-cycle phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (mc_tick) phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
    end

    // Count consecutive high samples of the reset pin, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '0;
        end else if (mc_tick) begin
            if (!rst_pin)      rcnt_q <= '0;
            else if (!rst_hold) rcnt_q <= rcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_wake_sel.sv
// Classifies pending requests as enabled wakes or recover-eligible disabled wakes.
// Assumes one request line (NOWAKE_IDX) may never wake while disabled.
module pwr_wake_sel #(
    parameter int N_IRQ      = 6,
    parameter int NOWAKE_IDX = 5
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             en_hit,
    output logic             dis_hit
);
    logic [N_IRQ-1:0] en_line;
    logic [N_IRQ-1:0] dis_line;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign en_line[i] = irq_req[i] & irq_en[i];
        if (i == NOWAKE_IDX) begin : g_excl
            assign dis_line[i] = 1'b0;
        end else begin : g_norm
            assign dis_line[i] = irq_req[i] & ~irq_en[i];
        end
    end

    assign en_hit  = |en_line;
    assign dis_hit = |dis_line;
endmodule

// File: rtl/pwr_t1_edge.sv
// Registers the timer-1 pin and flags its falling transition.
// Assumes t1_pin is synchronous to clk and idles high.
module pwr_t1_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic t1_pin,
    output logic t1_fall
);
    logic t1_prev_q;

    // Remember the previous pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) t1_prev_q <= 1'b1;
        else        t1_prev_q <= t1_pin;
    end

    assign t1_fall = t1_prev_q & ~t1_pin;
endmodule

// File: rtl/pwr_mode_reg.sv
// Power control register and mode sequencing: entry by write or pin edge,
// exit by interrupt, recover wake, pin level or qualified reset.
// Assumes writes only matter while the CPU is running.
module pwr_mode_reg
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rst_hold,
    input  logic       en_hit,
    input  logic       dis_hit,
    input  logic       t1_fall,
    input  logic       t1_pin,
    output pcon_t      pcon,
    output logic       hpd_act,
    output logic       resume
);
    pcon_t wd;
    pcon_t wr_val;

    // Shape write data: the unused bit reads zero and power-down beats idle.
    always_comb begin
        wd            = pcon_t'(wr_data);
        wr_val        = wd;
        wr_val.rsvd   = wd.rsvd & 1'b0;
        wr_val.idle   = wd.idle & ~wd.pd;
    end

    // Sequence the register, the hard power-down flag and the resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_hold) begin
            pcon    <= '0;
            hpd_act <= 1'b0;
            resume  <= 1'b0;
        end else begin
            resume <= 1'b0;
            if (hpd_act) begin
                if (t1_pin) hpd_act <= 1'b0;
            end else if (pcon.pd || pcon.idle) begin
                if (en_hit) begin
                    pcon.pd   <= 1'b0;
                    pcon.idle <= 1'b0;
                end else if (pcon.recover && dis_hit) begin
                    pcon.pd   <= 1'b0;
                    pcon.idle <= 1'b0;
                    resume    <= 1'b1;
                end
            end else begin
                if (wr_en)                    pcon    <= wr_val;
                if (t1_fall && pcon.hard_pd_arm) hpd_act <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the power state controller: derives the clock and oscillator enables,
// the port float request and the resume indication.
// Assumes clk keeps running in every state (always-on control domain).
module pwr_state_ctrl #(
    parameter int N_IRQ      = 6,
    parameter int NOWAKE_IDX = 5,
    parameter int OSC_PER_MC = 12,
    parameter int RST_MC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_data,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             t1_pin,
    input  logic             rst_pin,
    input  logic             float_cfg,
    output logic [7:0]       pcon_q,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             port_float,
    output logic             resume_nosvc
);
    import pwr_pkg::*;

    logic  rst_hold;
    logic  en_hit;
    logic  dis_hit;
    logic  t1_fall;
    logic  hpd_act;
    pcon_t pcon;

    pwr_mc_rst #(.OSC_PER_MC(OSC_PER_MC), .RST_MC(RST_MC)) u_rst (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .rst_hold(rst_hold)
    );

    pwr_wake_sel #(.N_IRQ(N_IRQ), .NOWAKE_IDX(NOWAKE_IDX)) u_wake (
        .irq_req(irq_req), .irq_en(irq_en), .en_hit(en_hit), .dis_hit(dis_hit)
    );

    pwr_t1_edge u_t1 (
        .clk(clk), .rst_n(rst_n), .t1_pin(t1_pin), .t1_fall(t1_fall)
    );

    pwr_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .rst_hold(rst_hold), .en_hit(en_hit), .dis_hit(dis_hit),
        .t1_fall(t1_fall), .t1_pin(t1_pin),
        .pcon(pcon), .hpd_act(hpd_act), .resume(resume_nosvc)
    );

    // Drive the enables from the registered mode state.
    always_comb begin
        pcon_q     = pcon;
        osc_en     = ~(pcon.pd | hpd_act);
        cpu_clk_en = osc_en & ~pcon.idle;
        port_float = float_cfg & ~osc_en;
    end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
// Checker for the power state controller, bound to the top module.
// Assumes it sees the top's ports and the internal hpd_act and rst_hold nets.
module pwr_state_ctrl_chk #(
    parameter int N_IRQ = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic [7:0]       pcon_q,
    input logic             cpu_clk_en,
    input logic             osc_en,
    input logic             port_float,
    input logic             resume_nosvc,
    input logic             hpd_act,
    input logic             rst_hold
);
    AST_PD_OVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pcon_q[1] |-> !pcon_q[0]); // R3

    AST_OSC_STOPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en); // R5

    AST_FLOAT_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        port_float |-> !osc_en); // R12

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && !rst_hold) |=> $stable(pcon_q[7:2])); // R6

    AST_ENABLED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pcon_q[1:0] != 2'b00) && !hpd_act && !rst_hold && ((irq_req & irq_en) != '0))
        |=> (pcon_q[1:0] == 2'b00) && !resume_nosvc); // R7

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_nosvc |=> !resume_nosvc); // R8

    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        resume_nosvc |-> cpu_clk_en); // R8

    AST_HARD_PD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_act |-> (!osc_en && !cpu_clk_en)); // R10

    AST_PIN_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold |=> (pcon_q == 8'h00)); // R11
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .pcon_q(pcon_q), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .port_float(port_float), .resume_nosvc(resume_nosvc),
    .hpd_act(hpd_act), .rst_hold(rst_hold)
);

// File: tb/pwr_state_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module pwr_state_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [5:0] irq_req = '0;
    logic [5:0] irq_en = '0;
    logic       t1_pin = 1'b1;
    logic       rst_pin = 1'b0;
    logic       float_cfg = 1'b0;
    logic [7:0] pcon_q;
    logic       cpu_clk_en, osc_en, port_float, resume_nosvc;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pwr_state_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .irq_req(irq_req), .irq_en(irq_en), .t1_pin(t1_pin), .rst_pin(rst_pin),
        .float_cfg(float_cfg), .pcon_q(pcon_q), .cpu_clk_en(cpu_clk_en),
        .osc_en(osc_en), .port_float(port_float), .resume_nosvc(resume_nosvc)
    );

    // Reference model state
    bit [7:0] m_pcon;
    bit       m_hpd, m_res, m_t1p;
    int       m_ph, m_rc;

    always @(posedge clk) begin : model
        bit hold, fall, enh, dish;
        if (!rst_n) begin
            m_pcon = 0; m_hpd = 0; m_res = 0; m_ph = 0; m_rc = 0; m_t1p = 1;
        end else begin
            hold = (m_rc >= 2);
            fall = m_t1p && !t1_pin;
            enh  = (irq_req & irq_en) != 0;
            dish = (irq_req & ~irq_en & 6'b011111) != 0;
            if (hold) begin
                m_pcon = 0; m_hpd = 0; m_res = 0;
            end else begin
                m_res = 0;
                if (m_hpd) begin
                    if (t1_pin) m_hpd = 0;
                end else if (m_pcon[1] || m_pcon[0]) begin
                    if (enh) m_pcon[1:0] = 0;
                    else if (m_pcon[5] && dish) begin m_pcon[1:0] = 0; m_res = 1; end
                end else begin
                    bit arm;
                    arm = m_pcon[6];
                    if (reg_wr_en) begin
                        m_pcon = reg_wr_data;
                        m_pcon[4] = 0;
                        if (m_pcon[1]) m_pcon[0] = 0;
                    end
                    if (fall && arm) m_hpd = 1;
                end
            end
            if (m_ph == 11) begin
                m_ph = 0;
                if (!rst_pin) m_rc = 0; else if (m_rc < 2) m_rc++;
            end else m_ph++;
            m_t1p = t1_pin;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare the design against the model every clock.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit e_osc, e_cpu;
            e_osc = !(m_pcon[1] || m_hpd);
            e_cpu = e_osc && !m_pcon[0];
            chk(cur_req, pcon_q, m_pcon, "model pcon_q");
            chk(cur_req, cpu_clk_en, e_cpu, "model cpu_clk_en");
            chk(cur_req, osc_en, e_osc, "model osc_en");
            chk(cur_req, port_float, float_cfg && !e_osc, "model port_float");
            chk(cur_req, resume_nosvc, m_res, "model resume_nosvc");
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        wait_n(3);
        cur_req = "R1";
        chk("R1", pcon_q, 8'h00, "pcon_q in reset");
        chk("R1", {cpu_clk_en, osc_en, port_float, resume_nosvc}, 4'b1100, "outputs in reset");
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", {cpu_clk_en, osc_en}, 2'b11, "enables after reset");

        cur_req = "R2";
        wr(8'hBC);
        chk("R2", pcon_q, 8'hAC, "stored fields, unused bit zero");
        chk("R2", cpu_clk_en, 1'b1, "still running");

        cur_req = "R4";
        wr(8'h01);
        chk("R4", {cpu_clk_en, osc_en}, 2'b01, "idle enables");
        cur_req = "R6";
        wr(8'h80);
        chk("R6", pcon_q, 8'h01, "write ignored in idle");
        cur_req = "R7";
        irq_en = 6'b000001; irq_req = 6'b000001;
        wait_n(1);
        irq_req = '0; irq_en = '0;
        chk("R7", pcon_q, 8'h00, "enabled wake clears idle");
        chk("R7", {cpu_clk_en, resume_nosvc}, 2'b10, "running, no resume pulse");

        cur_req = "R3";
        wr(8'h03);
        chk("R3", pcon_q, 8'h02, "power-down wins over idle");
        chk("R5", {cpu_clk_en, osc_en}, 2'b00, "power-down enables");
        cur_req = "R12";
        chk("R12", port_float, 1'b0, "no float when float_cfg=0");
        float_cfg = 1'b1; wait_n(1);
        chk("R12", port_float, 1'b1, "float in power-down");
        cur_req = "R9";
        irq_req = 6'b000010; wait_n(4);
        chk("R9", pcon_q, 8'h02, "disabled irq without recover");
        irq_en = 6'b000010; wait_n(1);
        irq_req = '0; irq_en = '0;
        chk("R7", pcon_q, 8'h00, "enabled wake from power-down");
        chk("R12", port_float, 1'b0, "no float when running");

        cur_req = "R8";
        wr(8'h21);
        irq_req = 6'b100000; wait_n(4);
        chk("R8", pcon_q, 8'h21, "excluded line does not wake");
        irq_req = 6'b100100; wait_n(1);
        irq_req = '0;
        chk("R8", pcon_q, 8'h20, "recover wake clears idle");
        chk("R8", resume_nosvc, 1'b1, "resume pulse");
        wait_n(1);
        chk("R8", resume_nosvc, 1'b0, "resume pulse one cycle");

        cur_req = "R10";
        wr(8'h00);
        t1_pin = 1'b0; wait_n(2);
        chk("R10", osc_en, 1'b1, "edge ignored when not armed");
        t1_pin = 1'b1; wait_n(1);
        wr(8'h40);
        t1_pin = 1'b0; wait_n(1);
        chk("R10", {cpu_clk_en, osc_en}, 2'b00, "hard power-down entered");
        chk("R12", port_float, 1'b1, "float in hard power-down");
        irq_en = 6'b000001; irq_req = 6'b000001; wait_n(3);
        irq_req = '0; irq_en = '0;
        chk("R10", {osc_en, pcon_q}, {1'b0, 8'h40}, "interrupt ignored, register kept");
        t1_pin = 1'b1; wait_n(1);
        chk("R10", {cpu_clk_en, osc_en}, 2'b11, "left on pin high");
        float_cfg = 1'b0;

        cur_req = "R11";
        wr(8'h05);
        rst_pin = 1'b1; wait_n(12);
        rst_pin = 1'b0; wait_n(14);
        chk("R11", pcon_q, 8'h05, "single sample does not reset");
        rst_pin = 1'b1; wait_n(36);
        chk("R11", pcon_q, 8'h00, "two samples clear register");
        rst_pin = 1'b0; wait_n(14);
        chk("R11", {cpu_clk_en, osc_en}, 2'b11, "running after pin reset");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule